// File: doc/BRIEF.md
# UART Receive Character Queue with Idle-Age Timeout

This block sits between a UART receiver front end and the register read path. Each received character enters a 32-entry queue, along with its framing-error indication. A line break also enters the queue as a tagged entry. A register read pops one entry per read. The block keeps the status a driver polls or takes as interrupts: receive ready against a programmable trigger level, data ready, empty, a sticky overrun, a sticky break-detected flag, and a sticky age flag.

The age flag covers a trickle of characters that never reaches the trigger level. While the queue holds data and receive ready is low, a countdown of `AGE_CYC` clock cycles runs. It is reloaded by every push and every pop. By default it lasts about eight 10-bit characters at 115200 baud with a 50 MHz clock. The soft-reset path drives a synchronous clear that empties the queue, stops the timer and drops all sticky flags.

Top module: `uart_rx_fifo_age`

## Requirements
- R1: After reset, and one cycle after `clr_i`, the block reads as follows: the queue is empty, `empty_o`=1, `data_ready_o`=0, `rx_ready_o`=0, every sticky flag is 0, `rd_word_o`=0, and the age timer is stopped.
- R2: Entries leave in arrival order.
  - While the queue is non-empty, `rd_word_o` shows the oldest entry, with bit 15 (valid) set and the character in bits 7:0.
  - A push with `push_ferr_i`=1 also sets bit 12 (framing) and bit 14 (error).
  - `rd_i` pops the entry at the clock edge.
  - When the queue is empty, `rd_word_o` is 0 and `rd_i` changes nothing.
- R3: A push into a full queue (32 entries) is dropped, and the stored entries are unchanged. It sets `overrun_o`, which stays set until reset or clear.
- R4: A push accepted while 31 entries are held stores its word with bit 13 (overrun tag) and bit 14 (error) set, in addition to the character.
- R5: `rx_ready_o` is updated only by pushes and pops.
  - A push sets it when the count after the push is at least `trig_lvl_i`.
  - A pop clears it when the remaining count is below `trig_lvl_i`.
  - With a trigger level of 0, a pop never clears it.
- R6: `data_ready_o` is 1 and `empty_o` is 0 exactly when the queue holds at least one entry.
- R7: A `brk_i` cycle pushes a word with bit 11 (break), bit 12 (framing) and bit 14 (error) set and character 0. It sets the sticky `brk_det_o`. It has priority over a `push_i` in the same cycle, so only the break word is stored.
- R8: When a push or pop leaves the queue non-empty with `rx_ready_o` low, `age_o` rises exactly `AGE_CYC` clock edges later, unless another push or pop restarts the count first. `age_o` then stays set until reset or clear.
- R9: The age timer does not run while `rx_ready_o` is high or the queue is empty, so no age event occurs in those states.
- R10: `clr_i` takes priority over a push, pop or break in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear from soft reset |
| push_i | input | 1 | Received character strobe |
| push_char_i | input | 8 | Received character |
| push_ferr_i | input | 1 | Framing error for the pushed character |
| brk_i | input | 1 | Line break event strobe |
| rd_i | input | 1 | Data register read strobe (pop) |
| trig_lvl_i | input | 6 | Receive trigger level, 0 to 32 |
| rd_word_o | output | 16 | Oldest entry with valid bit, or 0 when empty |
| rx_ready_o | output | 1 | Count reached the trigger level |
| data_ready_o | output | 1 | At least one entry held |
| empty_o | output | 1 | No entry held |
| overrun_o | output | 1 | Sticky: a push was dropped |
| age_o | output | 1 | Sticky: entries aged below the trigger level |
| brk_det_o | output | 1 | Sticky: break seen |

## Verification
The situations hardest to reach from the ports are the boundary of the last slot and the dropped push that follows it. To reach them, the bench sets the trigger level to 32 and pushes 33 distinct characters. It then drains the queue and checks three things: entry 31 alone carries the overrun tag, the 33rd character never appears, and receive ready rises only on the 32nd push. The age timeout is checked at the exact edge, one cycle either side. A second push at mid-count proves the restart, because the expected flag edge moves later by the same amount.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int unsigned CHAR_W  = 8;
  localparam int unsigned WORD_W  = 16;
  localparam int unsigned B_VALID = 15;
  localparam int unsigned B_ERR   = 14;
  localparam int unsigned B_OVR   = 13;
  localparam int unsigned B_FRM   = 12;
  localparam int unsigned B_BRK   = 11;

  function automatic logic [WORD_W-1:0] mk_word(input logic [CHAR_W-1:0] ch,
                                                input logic ferr,
                                                input logic brk,
                                                input logic last_slot);
    logic [WORD_W-1:0] w;
    w = '0;
    w[CHAR_W-1:0] = brk ? '0 : ch;
    w[B_FRM] = ferr | brk;
    w[B_BRK] = brk;
    w[B_OVR] = last_slot;
    w[B_ERR] = ferr | brk | last_slot;
    return w;
  endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned W     = 16,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             wr_i,
  input  logic [W-1:0]     wr_word_i,
  input  logic             rd_i,
  output logic [W-1:0]     head_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign head_o  = mem_q[rptr_q];
  assign cnt_o   = cnt_q;

  always_comb begin
    if (clr_i) cnt_nxt_o = '0;
    else       cnt_nxt_o = cnt_q + CNT_W'(wr_i) - CNT_W'(rd_i);
  end

  always_ff @(posedge clk_i) begin
    if (wr_i && !clr_i) mem_q[wptr_q] <= wr_word_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_i) wptr_q <= bump(wptr_q);
      if (rd_i) rptr_q <= bump(rptr_q);
      cnt_q <= cnt_nxt_o;
    end
  end

  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  a_r3_no_write_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !wr_i);
  a_r6_write_fills: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !clr_i) |=> !empty_o);
endmodule

// File: rtl/rxq_status.sv
module rxq_status #(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             push_ev_i,
  input  logic             drop_i,
  input  logic             brk_ev_i,
  input  logic             pop_i,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  input  logic [CNT_W-1:0] trig_i,
  output logic             rdy_nxt_o,
  output logic             rdy_o,
  output logic             ovr_o,
  output logic             brk_o
);
  logic rdy_q, ovr_q, brk_q;

  always_comb begin
    rdy_nxt_o = rdy_q;
    if (pop_i && (cnt_nxt_i < trig_i))      rdy_nxt_o = 1'b0;
    if (push_ev_i && (cnt_nxt_i >= trig_i)) rdy_nxt_o = 1'b1;
    if (clr_i)                              rdy_nxt_o = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q <= 1'b0;
      ovr_q <= 1'b0;
      brk_q <= 1'b0;
    end else if (clr_i) begin
      rdy_q <= 1'b0;
      ovr_q <= 1'b0;
      brk_q <= 1'b0;
    end else begin
      rdy_q <= rdy_nxt_o;
      if (drop_i)   ovr_q <= 1'b1;
      if (brk_ev_i) brk_q <= 1'b1;
    end
  end

  assign rdy_o = rdy_q;
  assign ovr_o = ovr_q;
  assign brk_o = brk_q;

  a_r3_ovr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_q && !clr_i) |=> ovr_q);
  a_r7_brk_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_ev_i && !clr_i) |=> brk_q);
  a_r10_clr_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !(rdy_q || ovr_q || brk_q));
endmodule

// File: rtl/rxq_age.sv
module rxq_age #(
  parameter int unsigned DEPTH   = 32,
  parameter int unsigned AGE_CYC = 34720,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1),
  localparam int unsigned TMR_W  = $clog2(AGE_CYC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             restart_i,
  input  logic             rdy_nxt_i,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  input  logic             rdy_i,
  input  logic             empty_i,
  output logic             age_o
);
  logic [TMR_W-1:0] tmr_q;
  logic             run_q, age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q <= '0;
      run_q <= 1'b0;
      age_q <= 1'b0;
    end else if (clr_i) begin
      tmr_q <= '0;
      run_q <= 1'b0;
      age_q <= 1'b0;
    end else if (restart_i) begin
      run_q <= !rdy_nxt_i && (cnt_nxt_i != '0);
      tmr_q <= TMR_W'(AGE_CYC);
    end else if (run_q) begin
      if (tmr_q == TMR_W'(1)) begin
        run_q <= 1'b0;
        age_q <= 1'b1;
      end else begin
        tmr_q <= tmr_q - TMR_W'(1);
      end
    end
  end

  assign age_o = age_q;

  a_r9_idle_when_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_i |-> !run_q);
  a_r9_idle_when_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_i |-> !run_q);
  a_r8_expire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && tmr_q == TMR_W'(1) && !restart_i && !clr_i) |=> age_q);
endmodule

// File: rtl/uart_rx_fifo_age.sv
module uart_rx_fifo_age
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH   = 32,
  parameter int unsigned AGE_CYC = 34720,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              push_i,
  input  logic [CHAR_W-1:0] push_char_i,
  input  logic              push_ferr_i,
  input  logic              brk_i,
  input  logic              rd_i,
  input  logic [CNT_W-1:0]  trig_lvl_i,
  output logic [WORD_W-1:0] rd_word_o,
  output logic              rx_ready_o,
  output logic              data_ready_o,
  output logic              empty_o,
  output logic              overrun_o,
  output logic              age_o,
  output logic              brk_det_o
);
  logic [WORD_W-1:0] head, in_word;
  logic [CNT_W-1:0]  cnt, cnt_nxt;
  logic              full, empty, push_ev, wr_ok, drop, pop_ok, rdy_nxt, rdy;

  assign push_ev = (push_i || brk_i) && !clr_i;
  assign wr_ok   = push_ev && !full;
  assign drop    = push_ev && full;
  assign pop_ok  = rd_i && !empty && !clr_i;
  assign in_word = mk_word(push_char_i, push_ferr_i && !brk_i, brk_i,
                           cnt == CNT_W'(DEPTH - 1));

  rxq_store #(.DEPTH(DEPTH), .W(WORD_W)) i_store (
    .clk_i, .rst_ni, .clr_i,
    .wr_i      (wr_ok),
    .wr_word_i (in_word),
    .rd_i      (pop_ok),
    .head_o    (head),
    .cnt_o     (cnt),
    .cnt_nxt_o (cnt_nxt),
    .full_o    (full),
    .empty_o   (empty)
  );

  rxq_status #(.DEPTH(DEPTH)) i_status (
    .clk_i, .rst_ni, .clr_i,
    .push_ev_i (push_ev),
    .drop_i    (drop),
    .brk_ev_i  (brk_i && !clr_i),
    .pop_i     (pop_ok),
    .cnt_nxt_i (cnt_nxt),
    .trig_i    (trig_lvl_i),
    .rdy_nxt_o (rdy_nxt),
    .rdy_o     (rdy),
    .ovr_o     (overrun_o),
    .brk_o     (brk_det_o)
  );

  rxq_age #(.DEPTH(DEPTH), .AGE_CYC(AGE_CYC)) i_age (
    .clk_i, .rst_ni, .clr_i,
    .restart_i (push_ev || pop_ok),
    .rdy_nxt_i (rdy_nxt),
    .cnt_nxt_i (cnt_nxt),
    .rdy_i     (rdy),
    .empty_i   (empty),
    .age_o     (age_o)
  );

  always_comb begin
    rd_word_o = '0;
    if (!empty) begin
      rd_word_o = head;
      rd_word_o[B_VALID] = 1'b1;
    end
  end

  assign rx_ready_o   = rdy;
  assign data_ready_o = !empty;
  assign empty_o      = empty;

  a_r2_empty_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> (rd_word_o == '0));
  a_r2_empty_read_no_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && rd_i && !push_i && !brk_i && !clr_i) |=> empty_o);
  a_r6_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_ready_o != empty_o);
endmodule

// File: tb/test_uart_rx_fifo_age.sv
module test_uart_rx_fifo_age;
  localparam int AGE = 40;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clr_i = 1'b0, push_i = 1'b0, push_ferr_i = 1'b0, brk_i = 1'b0, rd_i = 1'b0;
  logic [7:0]  push_char_i = '0;
  logic [5:0]  trig_lvl_i = 6'd2;
  logic [15:0] rd_word_o;
  logic        rx_ready_o, data_ready_o, empty_o, overrun_o, age_o, brk_det_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  uart_rx_fifo_age #(.DEPTH(32), .AGE_CYC(AGE)) i_uart_rx_fifo_age (.*);

  // op[31:30] 1 push 2 read 3 break, ferr[29], char[28:21], exp word[20:5], rdy/dr/emp/brk[4:1]
  localparam int NV = 9;
  localparam logic [31:0] VEC [NV] = '{
    {2'd1, 1'b0, 8'h41, 16'h0000, 4'b0100, 1'b0},
    {2'd1, 1'b1, 8'h42, 16'h0000, 4'b1100, 1'b0},
    {2'd2, 1'b0, 8'h00, 16'h8041, 4'b0100, 1'b0},
    {2'd2, 1'b0, 8'h00, 16'hD042, 4'b0010, 1'b0},
    {2'd2, 1'b0, 8'h00, 16'h0000, 4'b0010, 1'b0},
    {2'd3, 1'b0, 8'h00, 16'h0000, 4'b0101, 1'b0},
    {2'd1, 1'b0, 8'h7E, 16'h0000, 4'b1101, 1'b0},
    {2'd2, 1'b0, 8'h00, 16'hD800, 4'b0101, 1'b0},
    {2'd2, 1'b0, 8'h00, 16'h807E, 4'b0011, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] ch, input logic ferr);
    @(negedge clk_i);
    push_i = 1'b1; push_char_i = ch; push_ferr_i = ferr;
    @(posedge clk_i);
    @(negedge clk_i);
    push_i = 1'b0; push_ferr_i = 1'b0;
  endtask

  task automatic pop_chk(input string tag, input logic [15:0] exp);
    @(negedge clk_i);
    chk(tag, 32'(rd_word_o), 32'(exp));
    rd_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  task automatic do_clr();
    @(negedge clk_i);
    clr_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    clr_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 reset flags", {26'd0, rx_ready_o, data_ready_o, empty_o, overrun_o, age_o, brk_det_o},
        32'b001000);
    chk("R1 reset word", 32'(rd_word_o), 32'h0);

    // Table walk: R2 R5 R6 R7
    for (int v = 0; v < NV; v++) begin
      logic [31:0] e;
      e = VEC[v];
      @(negedge clk_i);
      if (e[31:30] == 2'd2) chk($sformatf("R2 vec%0d read word", v), 32'(rd_word_o), 32'(e[20:5]));
      push_i = (e[31:30] == 2'd1);
      rd_i   = (e[31:30] == 2'd2);
      brk_i  = (e[31:30] == 2'd3);
      push_ferr_i = e[29];
      push_char_i = e[28:21];
      @(posedge clk_i);
      @(negedge clk_i);
      push_i = 1'b0; rd_i = 1'b0; brk_i = 1'b0; push_ferr_i = 1'b0;
      chk($sformatf("R5 R6 R7 vec%0d flags", v),
          {28'd0, rx_ready_o, data_ready_o, empty_o, brk_det_o}, {28'd0, e[4:1]});
    end

    // R10 clear drops stickies
    push(8'h11, 1'b0);
    do_clr();
    chk("R10 clear flags", {26'd0, rx_ready_o, data_ready_o, empty_o, overrun_o, age_o, brk_det_o},
        32'b001000);

    // R7 break priority over same-cycle push
    @(negedge clk_i);
    push_i = 1'b1; brk_i = 1'b1; push_char_i = 8'h55;
    @(posedge clk_i);
    @(negedge clk_i);
    push_i = 1'b0; brk_i = 1'b0;
    pop_chk("R7 break word", 16'hD800);
    chk("R7 single entry", 32'(empty_o), 32'd1);
    do_clr();

    // R3 R4 R5 fill with trigger 32
    trig_lvl_i = 6'd32;
    for (int i = 0; i < 31; i++) push(8'(i), 1'b0);
    chk("R5 below trig 32", 32'(rx_ready_o), 32'd0);
    push(8'd31, 1'b0);
    chk("R5 at trig 32", 32'(rx_ready_o), 32'd1);
    chk("R3 no ovr yet", 32'(overrun_o), 32'd0);
    push(8'hAA, 1'b0);
    chk("R3 ovr sticky", 32'(overrun_o), 32'd1);
    for (int i = 0; i < 31; i++) pop_chk($sformatf("R2 R3 entry %0d", i), 16'h8000 | 16'(i));
    pop_chk("R4 last slot tag", 16'hE01F);
    chk("R3 dropped char absent", 32'(empty_o), 32'd1);
    chk("R3 ovr held", 32'(overrun_o), 32'd1);
    do_clr();

    // R8 exact expiry
    trig_lvl_i = 6'd4;
    push(8'h01, 1'b0);
    repeat (AGE - 1) @(posedge clk_i);
    @(negedge clk_i);
    chk("R8 not yet", 32'(age_o), 32'd0);
    @(posedge clk_i);
    @(negedge clk_i);
    chk("R8 expired", 32'(age_o), 32'd1);
    do_clr();

    // R8 restart by push
    push(8'h02, 1'b0);
    repeat (20) @(posedge clk_i);
    push(8'h03, 1'b0);
    repeat (AGE - 1) @(posedge clk_i);
    @(negedge clk_i);
    chk("R8 restart delays", 32'(age_o), 32'd0);
    @(posedge clk_i);
    @(negedge clk_i);
    chk("R8 restart expiry", 32'(age_o), 32'd1);
    do_clr();

    // R9 no age while ready
    trig_lvl_i = 6'd1;
    push(8'h04, 1'b0);
    chk("R9 ready", 32'(rx_ready_o), 32'd1);
    repeat (AGE + 5) @(posedge clk_i);
    @(negedge clk_i);
    chk("R9 no age when ready", 32'(age_o), 32'd0);

    // R5 trigger 0: pop never clears ready
    trig_lvl_i = 6'd0;
    pop_chk("R2 pop", 16'h8004);
    chk("R5 trig0 ready kept", 32'(rx_ready_o), 32'd1);
    chk("R6 empty after pop", {30'd0, data_ready_o, empty_o}, 32'b01);
    repeat (AGE + 5) @(posedge clk_i);
    @(negedge clk_i);
    chk("R9 no age when empty", 32'(age_o), 32'd0);

    // R10 clear with same-cycle push wins
    @(negedge clk_i);
    clr_i = 1'b1; push_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    clr_i = 1'b0; push_i = 1'b0;
    chk("R10 clear beats push", {30'd0, empty_o, rx_ready_o}, 32'b10);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule